// File: doc/BRIEF.md
# Indirect Extended PHY Register Write Sequencer

This block sits on the management side of an Ethernet PHY link. It turns one write to a PHY extended register into the four ordinary management-bus writes that the PHY's indirect access scheme needs. A request carries a PHY address, a 16-bit extended register address and a 16-bit data word. The block captures the request and then walks through four steps. Each step goes to a separate MDIO write engine, and before each step the block waits until that engine reports idle.

The four steps run in a fixed order:
1. Write a control word to the indirect control register (0xD) that selects address mode.
2. Write the extended address to the address/data register (0xE).
3. Write a control word to 0xD that selects data mode without post-increment.
4. Write the data word to 0xE. The PHY forwards this word to the selected extended register.

The FSM has four states:
- IDLE: ready for a request.
- WAIT: waits for the engine's busy flag to go low before the current step.
- ISSUE: holds the start request and its fields until the engine acknowledges.
- DRAIN: after the fourth acknowledge, waits for busy to go low, then pulses done.

The transitions are:
- accept: IDLE to WAIT.
- engine free: WAIT to ISSUE.
- step acknowledged: ISSUE to WAIT, or ISSUE to DRAIN after the fourth step.
- finish: DRAIN to IDLE.
- timeout: from any non-IDLE state to IDLE, with the error flag set.

Engine contract: the engine raises busy no later than the cycle after it acknowledges, and clears busy once the frame has been sent.

Top module: `ext_reg_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `eng_start`, `done` and `err` are 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. While a sequence is running, `req_ready` is 0 and `req_valid` is ignored: no extra engine writes occur and the captured fields do not change.
- R3: Before each step, the block waits for `eng_busy` to be 0. `eng_start` rises only after a cycle in which `eng_busy` was 0, and it stays low for as long as busy is held high.
- R4: Step 1 writes register 0xD with the control word 0x001F. In the control word, the function code is in bits 15:14 (0 = address mode), the device address 0x1F is in bits 4:0, and all other bits are zero.
- R5: Step 2 writes register 0xE with the requested extended register address.
- R6: Step 3 writes register 0xD with the control word 0x401F (function code 1 = data, no increment).
- R7: Step 4 writes register 0xE with the requested data word.
- R8: All four steps carry the PHY address captured at accept. Address 0 is the integrated PHY, and 0x01 to 0x1F select external PHYs.
- R9: While `eng_start` is high and `eng_ack` is low, `eng_start` and all engine fields hold steady into the next cycle.
- R10: After the fourth acknowledge and the busy flag clearing, `done` is high for exactly one cycle, and `req_ready` is high in that same cycle.
- R11: If the FSM stays in one non-IDLE state for TIMEOUT_CYCLES cycles, `err` is set, the block returns to IDLE, and `done` does not pulse. The next accepted request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Extended-write request |
| req_ready | output | 1 | High while idle; request accepted when both high |
| req_phy_addr | input | 5 | Target PHY address |
| req_ext_addr | input | 16 | Extended register address |
| req_wdata | input | 16 | Data for the extended register |
| eng_start | output | 1 | Start request to the MDIO write engine |
| eng_ack | input | 1 | Engine accepted the current step |
| eng_busy | input | 1 | Engine is transmitting a frame |
| eng_phy_addr | output | 5 | PHY address field for the engine |
| eng_reg_addr | output | 5 | Register address field for the engine |
| eng_wdata | output | 16 | Data field for the engine |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | Set by a timeout, cleared by the next accepted request |

## Verification
The bench holds `eng_busy` high from outside before a request. A sequencer that does not gate on busy would raise `eng_start` at once and log a write too early. A second request issued during a running sequence must leave the write log at four entries with the first request's values; a design that rearms from a busy state would log eight writes or mixed fields. The bench also checks the order of the 0xD/0xE writes and the two function codes, so a swapped step or a wrong bit position shows up directly in the log. Finally, an engine that never acknowledges must produce `err` and a return to ready without a done pulse, and the next request must clear the flag.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_ISSUE,
        S_DRAIN
    } seq_state_t;

    localparam logic [4:0] REG_CTRL     = 5'h0D;
    localparam logic [4:0] REG_ADDRDATA = 5'h0E;
    localparam logic [4:0] DEV_ADDR     = 5'h1F;
    localparam logic [1:0] FN_ADDRESS   = 2'd0;
    localparam logic [1:0] FN_DATA_NOINC = 2'd1;
    localparam int         STEP_COUNT   = 4;

endpackage

// File: rtl/ewr_step_encode.sv
module ewr_step_encode
    import ewr_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RAW = 5
) (
    input  logic [1:0]     step,
    input  logic [DW-1:0]  ext_addr,
    input  logic [DW-1:0]  wdata,
    output logic [RAW-1:0] reg_addr,
    output logic [DW-1:0]  reg_data
);
    localparam int PAD = DW - 2 - 5;

    logic [DW-1:0] ctl_addr_mode;
    logic [DW-1:0] ctl_data_mode;

    assign ctl_addr_mode = {FN_ADDRESS,    {PAD{1'b0}}, DEV_ADDR};
    assign ctl_data_mode = {FN_DATA_NOINC, {PAD{1'b0}}, DEV_ADDR};

    always_comb begin
        unique case (step)
            2'd0: begin
                reg_addr = RAW'(REG_CTRL);
                reg_data = ctl_addr_mode;
            end
            2'd1: begin
                reg_addr = RAW'(REG_ADDRDATA);
                reg_data = ext_addr;
            end
            2'd2: begin
                reg_addr = RAW'(REG_CTRL);
                reg_data = ctl_data_mode;
            end
            default: begin
                reg_addr = RAW'(REG_ADDRDATA);
                reg_data = wdata;
            end
        endcase
    end
endmodule

// File: rtl/ewr_watchdog.sv
module ewr_watchdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic progress,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !active || progress) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = active && !progress && (cnt_q == CW'(LIMIT - 1));

    // R11
    wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/ext_reg_write_seq.sv
module ext_reg_write_seq
    import ewr_pkg::*;
#(
    parameter int PHY_AW         = 5,
    parameter int REG_AW         = 5,
    parameter int DW             = 16,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PHY_AW-1:0] req_phy_addr,
    input  logic [DW-1:0]     req_ext_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              eng_start,
    input  logic              eng_ack,
    input  logic              eng_busy,
    output logic [PHY_AW-1:0] eng_phy_addr,
    output logic [REG_AW-1:0] eng_reg_addr,
    output logic [DW-1:0]     eng_wdata,
    output logic              done,
    output logic              err
);
    localparam logic [1:0] LAST_STEP = 2'(STEP_COUNT - 1);

    seq_state_t        state_q, state_d;
    logic [1:0]        step_q;
    logic [PHY_AW-1:0] phy_q;
    logic [DW-1:0]     ext_q, dat_q;
    logic              accept, finish, timeout, moved;

    assign accept = (state_q == S_IDLE) && req_valid;
    assign finish = (state_q == S_DRAIN) && !eng_busy;
    assign moved  = (state_d != state_q);

    ewr_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state_q != S_IDLE),
        .progress (moved),
        .expire   (timeout)
    );

    ewr_step_encode #(.DW(DW), .RAW(REG_AW)) u_enc (
        .step     (step_q),
        .ext_addr (ext_q),
        .wdata    (dat_q),
        .reg_addr (eng_reg_addr),
        .reg_data (eng_wdata)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_WAIT;
            S_WAIT:  if (!eng_busy) state_d = S_ISSUE;
            S_ISSUE: if (eng_ack) state_d = (step_q == LAST_STEP) ? S_DRAIN : S_WAIT;
            S_DRAIN: if (!eng_busy) state_d = S_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            phy_q   <= '0;
            ext_q   <= '0;
            dat_q   <= '0;
        end else if (timeout) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
            if (accept) begin
                step_q <= '0;
                phy_q  <= req_phy_addr;
                ext_q  <= req_ext_addr;
                dat_q  <= req_wdata;
            end else if (state_q == S_ISSUE && eng_ack && step_q != LAST_STEP) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= finish && !timeout;
            if (timeout)     err <= 1'b1;
            else if (accept) err <= 1'b0;
        end
    end

    assign req_ready    = (state_q == S_IDLE);
    assign eng_start    = (state_q == S_ISSUE);
    assign eng_phy_addr = phy_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R3
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_start) |-> !$past(eng_busy));

    // R9
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !eng_ack && !timeout) |=>
            (eng_start && $stable(eng_reg_addr) && $stable(eng_wdata) && $stable(eng_phy_addr)));

    // R2
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !eng_start);

    // R11
    err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (req_ready && !done));

    // R4
    reg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_reg_addr == REG_AW'(REG_CTRL) || eng_reg_addr == REG_AW'(REG_ADDRDATA)));
endmodule

// File: tb/test_ext_reg_write_seq.sv
module test_ext_reg_write_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ENG_LAT    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_phy_addr = '0;
    logic [15:0] req_ext_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        eng_start;
    logic        eng_ack = 1'b0;
    logic        eng_busy;
    logic [4:0]  eng_phy_addr;
    logic [4:0]  eng_reg_addr;
    logic [15:0] eng_wdata;
    logic        done, err;

    logic        model_busy = 1'b0;
    logic        force_busy = 1'b0;
    logic        eng_mute = 1'b0;
    int          lat_cnt = 0;
    int          wr_cnt = 0;
    logic [4:0]  log_reg [0:63];
    logic [15:0] log_dat [0:63];
    logic [4:0]  log_phy [0:63];

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign eng_busy = model_busy | force_busy;

    ext_reg_write_seq i_ext_reg_write_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_phy_addr(req_phy_addr), .req_ext_addr(req_ext_addr), .req_wdata(req_wdata),
        .eng_start(eng_start), .eng_ack(eng_ack), .eng_busy(eng_busy),
        .eng_phy_addr(eng_phy_addr), .eng_reg_addr(eng_reg_addr), .eng_wdata(eng_wdata),
        .done(done), .err(err)
    );

    // Behavioural MDIO write engine
    always @(posedge clk) begin
        if (eng_ack) begin
            eng_ack    <= 1'b0;
            model_busy <= 1'b1;
            lat_cnt    <= ENG_LAT;
        end else if (model_busy) begin
            if (lat_cnt <= 1) model_busy <= 1'b0;
            lat_cnt <= lat_cnt - 1;
        end else if (eng_start && !eng_mute && !force_busy) begin
            eng_ack <= 1'b1;
            log_reg[wr_cnt[5:0]] <= eng_reg_addr;
            log_dat[wr_cnt[5:0]] <= eng_wdata;
            log_phy[wr_cnt[5:0]] <= eng_phy_addr;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] phy, input logic [15:0] ea, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_phy_addr = phy; req_ext_addr = ea; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output int seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic check_log(input int base, input logic [4:0] phy,
                             input logic [15:0] ea, input logic [15:0] wd);
        check("R4 step1 reg", {27'd0, log_reg[base]},   32'h0D);
        check("R4 step1 data", {16'd0, log_dat[base]},  32'h001F);
        check("R5 step2 reg", {27'd0, log_reg[base+1]}, 32'h0E);
        check("R5 step2 data", {16'd0, log_dat[base+1]}, {16'd0, ea});
        check("R6 step3 reg", {27'd0, log_reg[base+2]}, 32'h0D);
        check("R6 step3 data", {16'd0, log_dat[base+2]}, 32'h401F);
        check("R7 step4 reg", {27'd0, log_reg[base+3]}, 32'h0E);
        check("R7 step4 data", {16'd0, log_dat[base+3]}, {16'd0, wd});
        for (int k = 0; k < 4; k++)
            check("R8 phy addr", {27'd0, log_phy[base+k]}, {27'd0, phy});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready", {31'd0, req_ready}, 1);
        check("R1 start", {31'd0, eng_start}, 0);
        check("R1 done", {31'd0, done}, 0);
        check("R1 err", {31'd0, err}, 0);
    endtask

    task automatic t_basic(input logic [4:0] phy, input logic [15:0] ea, input logic [15:0] wd);
        int base, seen;
        base = wr_cnt;
        send(phy, ea, wd);
        wait_done(seen);
        check("R10 done seen", seen, 1);
        check("R10 ready with done", {31'd0, req_ready}, 1);
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 0);
        check("R10 write count", wr_cnt - base, 4);
        check_log(base, phy, ea, wd);
    endtask

    task automatic t_busy_gate;
        int base, seen;
        base = wr_cnt;
        @(negedge clk); force_busy = 1'b1;
        send(5'h03, 16'h1234, 16'hBEEF);
        repeat (10) begin
            @(negedge clk);
            check("R3 no start while busy", {31'd0, eng_start}, 0);
        end
        check("R3 no write while busy", wr_cnt - base, 0);
        force_busy = 1'b0;
        wait_done(seen);
        check("R3 done after release", seen, 1);
        check_log(base, 5'h03, 16'h1234, 16'hBEEF);
    endtask

    task automatic t_ignore;
        int base, seen;
        base = wr_cnt;
        send(5'h11, 16'h00AA, 16'h5555);
        repeat (3) @(negedge clk);
        check("R2 not ready mid-sequence", {31'd0, req_ready}, 0);
        send(5'h07, 16'hFFFF, 16'h0000);
        wait_done(seen);
        check("R2 done", seen, 1);
        repeat (20) @(negedge clk);
        check("R2 extra request ignored", wr_cnt - base, 4);
        check_log(base, 5'h11, 16'h00AA, 16'h5555);
    endtask

    task automatic t_timeout;
        int base, seen;
        base = wr_cnt;
        seen = 0;
        eng_mute = 1'b1;
        send(5'h02, 16'h0101, 16'h0202);
        for (int i = 0; i < 3000; i++) begin
            if (done) seen = 1;
            if (req_ready) break;
            @(negedge clk);
        end
        check("R11 back to ready", {31'd0, req_ready}, 1);
        check("R11 err set", {31'd0, err}, 1);
        check("R11 no done", seen, 0);
        check("R11 no write", wr_cnt - base, 0);
        eng_mute = 1'b0;
        send(5'h02, 16'h0101, 16'h0202);
        check("R11 err cleared", {31'd0, err}, 0);
        wait_done(seen);
        check("R11 recovers", seen, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_basic(5'h00, 16'h0031, 16'hA5C3);
        t_basic(5'h1F, 16'hFFFF, 16'h0000);
        t_basic(5'h01, 16'h8000, 16'hFFFF);
        t_busy_gate();
        t_ignore();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule